// File: doc/BRIEF.md
# Latching interrupt polarity adapter

This block is a per-line front end placed between peripheral interrupt sources and a parent interrupt controller that accepts only active-high level requests. Every line passes through a synchroniser and an optional inverter, so a source that signals with a low level or a falling edge still presents a high level to the parent. Each line also has a mask bit that holds its request low.

A build-time parameter picks one of two variants. In the latching variant, an active edge sets a per-line status flop. The request stays high until software writes a one to that line's end-of-interrupt bit, and the line raises again only on a fresh active edge. In the pass-through variant there is no status flop and no end-of-interrupt: the request follows the synchronised, optionally inverted input. Software reaches the mask, inversion and status banks through a 16-bit register read/write port.

Top module: `irq_polarity_latch`

## Requirements
- R1: After reset all implemented mask bits read 1, all inversion bits read 0, all status bits read 0, and every request output is low.
- R2: Registers are 16 bits wide and 4 bytes apart. Mask bank at 0x00, inversion bank at 0x10, end-of-interrupt/status bank at 0x20. Line n sits in register n/16 of a bank at bit n%16. Bits for lines at or above the line count, and unmapped or misaligned addresses, read 0 and ignore writes.
- R3: When a line's inversion bit is 1 the synchronised input is inverted before edge detection and output, so a falling input edge is captured as an active edge.
- R4: In the latching variant an active edge sets the line's status. With the default two-stage synchroniser the request rises on the third clock edge after the input changes.
- R5: In the latching variant a set status, and its request, stay high after the input returns inactive.
- R6: Writing 1 to a bit of the end-of-interrupt bank clears that line's status on the write edge. Writing 0 leaves it unchanged. Reads of that bank return the status bits.
- R7: After a clear, an input still held active does not raise the request again; only a new active edge does.
- R8: A mask bit of 1 forces that line's request low. In the latching variant edges arriving while masked are still captured, and the request appears once the line is unmasked.
- R9: If an end-of-interrupt write and a new active edge reach the same line in the same cycle, the status stays set.
- R10: In the pass-through variant the request equals the synchronised input XOR inversion, ANDed with NOT mask, two clock edges after an input change. The status bank reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt inputs from sources, asynchronous |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_out | output | NUM_LINES | Active-high level requests to the parent controller |

## Verification
The checker assumes every raw input is held long enough to cross the synchroniser, and that an end-of-interrupt write is a one-cycle strobe. With those assumptions, status is set only by a detected edge and is cleared only by a write that does not coincide with one. The random stimulus holds each input and configuration change for three clocks before the next action, which keeps it inside those assumptions. A bench model updates its expected status once per step from the settled levels. The same-cycle race between a clear and a new edge is placed on its exact clock edge by a directed case.

// File: rtl/irqpol_pkg.sv
package irqpol_pkg;
   localparam int REG_W     = 16;
   localparam int MAX_LINES = 64;
   localparam int MAX_REGS  = MAX_LINES / REG_W;

   typedef enum logic [1:0] {
      BANK_MASK = 2'd0,
      BANK_INV  = 2'd1,
      BANK_ACK  = 2'd2,
      BANK_NONE = 2'd3
   } bank_e;

   function automatic int regs_for(input int lines);
      return (lines + REG_W - 1) / REG_W;
   endfunction
endpackage

// File: rtl/irqpol_regs.sv
module irqpol_regs
   import irqpol_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   input  logic [NUM_LINES-1:0] held,
   output logic [REG_W-1:0]     rdata,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] inv_q,
   output logic [NUM_LINES-1:0] ack_clr
);
   localparam int PAD_W = MAX_REGS * REG_W;

   logic        page_ok;
   logic        sel_ok;
   bank_e       bank;
   logic [1:0]  slot;

   generate
      if (ADDR_W > 6) begin : g_page
         assign page_ok = (addr[ADDR_W-1:6] == '0);
      end else begin : g_nopage
         assign page_ok = 1'b1;
      end
   endgenerate

   assign bank   = bank_e'(addr[5:4]);
   assign slot   = addr[3:2];
   assign sel_ok = page_ok && (addr[1:0] == 2'b00);

   // bit i of a bank lives in register i/REG_W at position i%REG_W
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         inv_q  <= '0;
      end else if (we && sel_ok) begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (slot == 2'(i / REG_W)) begin
               if (bank == BANK_MASK) mask_q[i] <= wdata[i % REG_W];
               if (bank == BANK_INV)  inv_q[i]  <= wdata[i % REG_W];
            end
         end
      end
   end

   always_comb begin
      ack_clr = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         ack_clr[i] = we && sel_ok && (bank == BANK_ACK) &&
                      (slot == 2'(i / REG_W)) && wdata[i % REG_W];
      end
   end

   logic [PAD_W-1:0] mask_pad, inv_pad, held_pad;

   always_comb begin
      mask_pad = '0;
      inv_pad  = '0;
      held_pad = '0;
      mask_pad[NUM_LINES-1:0] = mask_q;
      inv_pad[NUM_LINES-1:0]  = inv_q;
      held_pad[NUM_LINES-1:0] = held;
   end

   always_comb begin
      rdata = '0;
      if (sel_ok) begin
         unique case (bank)
            BANK_MASK: rdata = mask_pad[slot*REG_W +: REG_W];
            BANK_INV:  rdata = inv_pad[slot*REG_W +: REG_W];
            BANK_ACK:  rdata = held_pad[slot*REG_W +: REG_W];
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irqpol_line.sv
module irqpol_line #(
   parameter bit LATCHING    = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic inv,
   input  logic mask,
   input  logic ack,
   output logic req,
   output logic held,
   output logic hit
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   // polarity is normalised before edge detection and output
   assign lvl = sync_q[SYNC_STAGES-1] ^ inv;

   generate
      if (LATCHING) begin : g_latch
         logic prev_q;
         logic held_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               held_q <= 1'b0;
            end else begin
               prev_q <= lvl;
               // a new edge overrides a clear in the same cycle
               held_q <= hit | (held_q & ~ack);
            end
         end

         assign hit  = lvl & ~prev_q;
         assign held = held_q;
         assign req  = held_q & ~mask;
      end else begin : g_pass
         logic unused_ack;
         assign unused_ack = ack;
         assign hit  = 1'b0;
         assign held = 1'b0;
         assign req  = lvl & ~mask;
      end
   endgenerate
endmodule

// File: rtl/irq_polarity_latch.sv
module irq_polarity_latch
   import irqpol_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter bit LATCHING    = 1'b1,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic [NUM_LINES-1:0] irq_out
);
   localparam int NREG = regs_for(NUM_LINES);

   initial begin : param_check
      assert (NUM_LINES >= 1 && NUM_LINES <= MAX_LINES)
         else $error("NUM_LINES must be 1..%0d", MAX_LINES);
      assert (NREG <= MAX_REGS)
         else $error("too many bank registers");
      assert (ADDR_W >= 6)
         else $error("ADDR_W must cover the bank offsets");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] inv_q;
   logic [NUM_LINES-1:0] ack_clr;
   logic [NUM_LINES-1:0] stat_q;
   logic [NUM_LINES-1:0] edge_hit;

   irqpol_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .held    (stat_q),
      .rdata   (reg_rdata),
      .mask_q  (mask_q),
      .inv_q   (inv_q),
      .ack_clr (ack_clr)
   );

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
         irqpol_line #(
            .LATCHING    (LATCHING),
            .SYNC_STAGES (SYNC_STAGES)
         ) i_line (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (irq_in[g]),
            .inv   (inv_q[g]),
            .mask  (mask_q[g]),
            .ack   (ack_clr[g]),
            .req   (irq_out[g]),
            .held  (stat_q[g]),
            .hit   (edge_hit[g])
         );
      end
   endgenerate
endmodule

// File: rtl/irqpol_checker.sv
module irqpol_checker #(
   parameter int NUM_LINES = 32,
   parameter bit LATCHING  = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] mask,
   input logic [NUM_LINES-1:0] status,
   input logic [NUM_LINES-1:0] ack_clr,
   input logic [NUM_LINES-1:0] edge_hit,
   input logic [NUM_LINES-1:0] irq_out
);
   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
         assert_masked_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            mask[g] |-> !irq_out[g]);

         if (LATCHING) begin : g_lat
            assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (status[g] && !ack_clr[g]) |=> status[g]);

            assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (ack_clr[g] && !edge_hit[g]) |=> !status[g]);

            assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
               (ack_clr[g] && edge_hit[g]) |=> status[g]);

            assert_rise_from_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(status[g]) |-> $past(edge_hit[g]));
         end else begin : g_pt
            assert_no_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
               $stable(status[g]));
         end
      end
   endgenerate
endmodule

bind irq_polarity_latch irqpol_checker #(
   .NUM_LINES (NUM_LINES),
   .LATCHING  (LATCHING)
) u_irqpol_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .mask     (mask_q),
   .status   (stat_q),
   .ack_clr  (ack_clr),
   .edge_hit (edge_hit),
   .irq_out  (irq_out)
);

// File: tb/test_irq_polarity_latch.sv
`timescale 1ns/100ps
module test_irq_polarity_latch;
   localparam int N  = 20;
   localparam int AW = 8;
   localparam logic [N-1:0] IMPL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   rd_lat, rd_pt;
   logic [N-1:0]  out_lat, out_pt;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_polarity_latch #(.NUM_LINES(N), .LATCHING(1'b1), .ADDR_W(AW)) i_irq_polarity_latch (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd_lat), .irq_out(out_lat));

   irq_polarity_latch #(.NUM_LINES(N), .LATCHING(1'b0), .ADDR_W(AW)) i_irq_polarity_latch_pt (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd_pt), .irq_out(out_pt));

   function automatic logic [N-1:0] exp_lat_out(input logic [N-1:0] st, input logic [N-1:0] m);
      return st & ~m;
   endfunction

   function automatic logic [N-1:0] exp_pt_out(input logic [N-1:0] in, input logic [N-1:0] inv,
                                                input logic [N-1:0] m);
      return (in ^ inv) & ~m;
   endfunction

   function automatic logic [15:0] slice16(input logic [N-1:0] v, input int k);
      logic [31:0] p;
      p = 32'(v);
      return p[k*16 +: 16];
   endfunction

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      reg_we = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      tick();
      reg_we = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] dl, output logic [15:0] dp);
      reg_addr = a;
      #0.5;
      dl = rd_lat;
      dp = rd_pt;
   endtask

   task automatic do_reset();
      irq_in = '0;
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] a, b;
      logic [N-1:0] m_mask, m_inv, m_stat, m_lvl, nl, wv;

      do_reset();

      // R1 reset state
      rd(8'h00, a, b); chk("R1 mask reg0", a, 16'hFFFF);
      rd(8'h04, a, b); chk("R1 mask reg1 (R2 unimplemented bits)", a, 16'h000F);
      rd(8'h10, a, b); chk("R1 inv reg0", a, 16'h0000);
      rd(8'h20, a, b); chk("R1 status reg0", a, 16'h0000);
      chk("R1 outputs", {out_lat, out_pt}, '0);

      // R2 map and readback
      wr(8'h00, 16'h0000);
      wr(8'h04, 16'hFFF0);
      rd(8'h04, a, b); chk("R2 mask reg1 readback", a, 16'h0000);
      wr(8'h08, 16'hFFFF);
      rd(8'h08, a, b); chk("R2 unmapped reg reads 0", a, 16'h0000);
      wr(8'h01, 16'hFFFF);
      rd(8'h00, a, b); chk("R2 misaligned write ignored", a, 16'h0000);
      wr(8'h14, 16'h0004);
      rd(8'h14, a, b); chk("R2 inv reg1 bit2 = line 18", a, 16'h0004);
      chk("R2 line 18 inversion reaches output", 32'(out_pt[18]), 32'd1);
      tick(2);
      rd(8'h24, a, b); chk("R2 status reg1 bit2 = line 18", a, 16'h0004);
      wr(8'h14, 16'h0000);
      wr(8'h24, 16'h0004);

      // R4 / R10 latency
      irq_in[3] = 1'b1;
      tick(2);
      chk("R10 pass-through after two edges", 32'(out_pt[3]), 32'd1);
      chk("R4 latch not yet risen", 32'(out_lat[3]), 32'd0);
      tick();
      chk("R4 latch risen on third edge", 32'(out_lat[3]), 32'd1);
      rd(8'h20, a, b);
      chk("R6 status readback", a, 16'h0008);
      chk("R10 pass-through status reads 0", b, 16'h0000);

      // R5 hold
      irq_in[3] = 1'b0;
      tick(3);
      chk("R5 status held after input drop", 32'(out_lat[3]), 32'd1);
      chk("R10 pass-through follows drop", 32'(out_pt[3]), 32'd0);

      // R6 clear
      wr(8'h20, 16'h0000);
      chk("R6 zero write no effect", 32'(out_lat[3]), 32'd1);
      wr(8'h20, 16'h0008);
      chk("R6 one write clears", 32'(out_lat[3]), 32'd0);

      // R7 no re-trigger on held level
      irq_in[3] = 1'b1;
      tick(3);
      wr(8'h20, 16'h0008);
      tick(4);
      chk("R7 held level does not re-trigger", 32'(out_lat[3]), 32'd0);
      irq_in[3] = 1'b0;
      tick(3);
      irq_in[3] = 1'b1;
      tick(3);
      chk("R7 new edge re-triggers", 32'(out_lat[3]), 32'd1);
      irq_in[3] = 1'b0;
      tick(3);
      wr(8'h20, 16'h0008);

      // R3 falling edge via inversion
      irq_in[7] = 1'b1;
      tick(3);
      wr(8'h20, 16'h0080);
      wr(8'h10, 16'h0080);
      tick(3);
      chk("R3 inverted high level gives no edge", 32'(out_lat[7]), 32'd0);
      chk("R3 pass-through inverted high is low", 32'(out_pt[7]), 32'd0);
      irq_in[7] = 1'b0;
      tick(3);
      chk("R3 falling edge captured", 32'(out_lat[7]), 32'd1);
      chk("R3 pass-through inverted low is high", 32'(out_pt[7]), 32'd1);
      wr(8'h10, 16'h0000);
      tick(3);
      wr(8'h20, 16'h0080);

      // R8 mask with capture
      wr(8'h00, 16'h0400);
      irq_in[10] = 1'b1;
      tick(3);
      chk("R8 masked output low", 32'(out_lat[10]), 32'd0);
      chk("R8 masked pass-through low", 32'(out_pt[10]), 32'd0);
      rd(8'h20, a, b); chk("R8 edge captured while masked", a, 16'h0400);
      wr(8'h00, 16'h0000);
      chk("R8 request after unmask", 32'(out_lat[10]), 32'd1);
      irq_in[10] = 1'b0;
      tick(3);
      wr(8'h20, 16'h0400);

      // R9 same-cycle clear and edge
      irq_in[12] = 1'b1;
      tick(3);
      irq_in[12] = 1'b0;
      tick(3);
      chk("R9 precondition status set", 32'(out_lat[12]), 32'd1);
      irq_in[12] = 1'b1;
      tick(2);
      wr(8'h20, 16'h1000);
      tick(2);
      chk("R9 edge wins over clear", 32'(out_lat[12]), 32'd1);
      wr(8'h20, 16'h1000);
      tick(3);
      chk("R9 later clear works (R7 held high)", 32'(out_lat[12]), 32'd0);

      // random phase
      do_reset();
      void'($urandom(32'h1A2B3C4D));
      m_mask = IMPL;
      m_inv  = '0;
      m_stat = '0;
      m_lvl  = '0;
      for (int s = 0; s < 300; s++) begin
         int act, k;
         logic [15:0] d;
         act = $urandom % 4;
         k   = $urandom % 2;
         d   = 16'($urandom);
         wv  = N'(32'(d) << (16*k));
         case (act)
            0: irq_in = N'($urandom);
            1: begin
               wr(8'(4*k), d);
               m_mask = (m_mask & ~(N'(32'hFFFF << (16*k)))) | wv;
            end
            2: begin
               wr(8'(8'h10 + 4*k), d);
               m_inv = (m_inv & ~(N'(32'hFFFF << (16*k)))) | wv;
            end
            default: begin
               wr(8'(8'h20 + 4*k), d);
               m_stat = m_stat & ~wv;
            end
         endcase
         tick(3);
         nl = irq_in ^ m_inv;
         m_stat = m_stat | (nl & ~m_lvl);
         m_lvl = nl;
         chk("R4/R8 random latch output", 32'(out_lat), 32'(exp_lat_out(m_stat, m_mask)));
         chk("R3/R10 random pass-through output", 32'(out_pt), 32'(exp_pt_out(irq_in, m_inv, m_mask)));
         rd(8'h20, a, b); chk("R6 random status reg0", a, slice16(m_stat, 0));
         rd(8'h24, a, b); chk("R6 random status reg1", a, slice16(m_stat, 1));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule